// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Zero and Overflow Flags

This block is the combinational arithmetic and logic unit of a small integer core. It takes two operands and a four-bit control word and returns a result word with two status flags. The control word holds an operation select in its low three bits and an invert-B bit at bit 3. The invert-B bit has two uses. For logic operations it applies the operation to the complement of B. For the arithmetic operation it turns addition into subtraction.

The datapath is a row of identical one-bit cells fed by one ripple carry chain. Subtraction reuses the adder: B is complemented and the chain's carry-in is set to 1. Both comparisons (signed and unsigned) run a subtraction internally and return their answer in bit 0, with every other result bit cleared.

The zero flag is derived from the result word. The overflow flag comes from the carries around the most significant bit, and an unsigned-mode input masks it.

Top module: `sliced_alu`

## Requirements
- R1: With select 000, 001, 010 or 011 the result is A AND B', A OR B', A XOR B' or NOR(A, B'). B' is B when ctl[3]=0 and the complement of B when ctl[3]=1.
- R2: With select 100 and ctl[3]=0 the result is (A + B) mod 2^32.
- R3: With select 100 and ctl[3]=1 the result is (A - B) mod 2^32.
- R4: With select 101 the result is 1 when A < B as signed two's-complement numbers and 0 otherwise. This holds even when the internal difference overflows, and whatever the value of ctl[3]. Bits 31..1 are then 0.
- R5: With select 110 the result is 1 when A < B as unsigned numbers and 0 otherwise, whatever the value of ctl[3]. Bits 31..1 are then 0.
- R6: Select 111 gives an all-zero result and no overflow.
- R7: zero is 1 exactly when all 32 result bits are 0, for every operation.
- R8: With select 100 and unsigned_mode=0, ovf is 1 exactly when the signed sum or difference does not fit in 32 bits. An addition of operands with opposite signs never sets ovf.
- R9: While unsigned_mode=1, ovf is 0 for every operation and operand.
- R10: For every select other than 100, ovf is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| ctl | input | 4 | Bit 3 is invert-B / subtract; bits 2..0 are the operation select |
| unsigned_mode | input | 1 | Marks unsigned arithmetic; masks ovf |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of add/subtract |

## Verification
The directed cases aim at the overflow boundaries: max-positive plus one, min-negative minus one, and min plus min, which wraps to zero and so also raises zero. A design that took overflow from the carry-out alone would miss these cases or flag false ones. The signed comparison is tried at operand pairs whose difference overflows, such as min against 1 and max against -1. A comparator that used only the difference sign returns the inverted answer there. The unsigned comparison is run on the same pairs and must disagree with the signed one, and a swapped borrow sense shows up as inverted results. The inverted-B logic variants, the unused select and the unsigned mask are each checked, and random operands are checked against an arithmetic reference.

// File: rtl/salu_pkg.sv
package salu_pkg;

    localparam int unsigned SEL_W = 3;
    localparam int unsigned CTL_W = SEL_W + 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND   = 3'b000,
        SEL_OR    = 3'b001,
        SEL_XOR   = 3'b010,
        SEL_NOR   = 3'b011,
        SEL_ARITH = 3'b100,
        SEL_SLT   = 3'b101,
        SEL_SLTU  = 3'b110,
        SEL_RSVD  = 3'b111
    } alu_sel_e;

    typedef struct packed {
        alu_sel_e sel;
        logic     invert_b;
        logic     carry_in;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
    import salu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]     b_in,
    input  logic [CTL_W-1:0] ctl,
    output logic [W-1:0]     b_eff,
    output alu_ctrl_t        ctrl
);

    alu_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d.sel = alu_sel_e'(ctl[SEL_W-1:0]);
        // comparisons always subtract; otherwise the top control bit decides
        ctrl_d.invert_b = ctl[CTL_W-1]
                        | (ctrl_d.sel == SEL_SLT)
                        | (ctrl_d.sel == SEL_SLTU);
        ctrl_d.carry_in = ctrl_d.invert_b & (ctrl_d.sel inside {SEL_ARITH, SEL_SLT, SEL_SLTU});
    end

    assign ctrl  = ctrl_d;
    assign b_eff = ctrl_d.invert_b ? ~b_in : b_in;

endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W:0]   carry
);

    always_comb begin
        carry[0] = cin;
        for (int i = 0; i < W; i++) begin
            carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
        end
    end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
    import salu_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     cin,
    input  logic     less,
    input  alu_sel_e sel,
    output logic     res
);

    logic sum_bit;

    assign sum_bit = a ^ b ^ cin;

    always_comb begin
        unique case (sel)
            SEL_AND:   res = a & b;
            SEL_OR:    res = a | b;
            SEL_XOR:   res = a ^ b;
            SEL_NOR:   res = ~(a | b);
            SEL_ARITH: res = sum_bit;
            SEL_SLT,
            SEL_SLTU:  res = less;
            default:   res = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import salu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         a_msb,
    input  logic         b_msb,
    input  logic         c_into_msb,
    input  logic         c_out_msb,
    input  alu_sel_e     sel,
    input  logic         unsigned_mode,
    input  logic [W-1:0] res,
    output logic         set_bit,
    output logic         zero,
    output logic         ovf
);

    logic diff_sign;
    logic raw_ovf;

    assign diff_sign = a_msb ^ b_msb ^ c_into_msb;
    assign raw_ovf   = c_into_msb ^ c_out_msb;

    always_comb begin
        unique case (sel)
            SEL_SLT:  set_bit = diff_sign ^ raw_ovf;
            SEL_SLTU: set_bit = ~c_out_msb;
            default:  set_bit = 1'b0;
        endcase
    end

    assign ovf  = raw_ovf & (sel == SEL_ARITH) & ~unsigned_mode;
    assign zero = ~|res;

endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
    import salu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [CTL_W-1:0] ctl,
    input  logic             unsigned_mode,
    output logic [W-1:0]     result,
    output logic             zero,
    output logic             ovf
);

    localparam int unsigned MSB = W - 1;

    logic [W-1:0] b_eff;
    alu_ctrl_t    ctrl;
    logic [W:0]   carry;
    logic         set_bit;

    alu_operand_prep #(.W(W)) prep_i (
        .b_in  (opb),
        .ctl   (ctl),
        .b_eff (b_eff),
        .ctrl  (ctrl)
    );

    alu_carry_chain #(.W(W)) chain_i (
        .a     (opa),
        .b     (b_eff),
        .cin   (ctrl.carry_in),
        .carry (carry)
    );

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i == 0) begin : g_low
            alu_bit_cell cell_i (
                .a    (opa[i]),
                .b    (b_eff[i]),
                .cin  (carry[i]),
                .less (set_bit),
                .sel  (ctrl.sel),
                .res  (result[i])
            );
        end else begin : g_up
            alu_bit_cell cell_i (
                .a    (opa[i]),
                .b    (b_eff[i]),
                .cin  (carry[i]),
                .less (1'b0),
                .sel  (ctrl.sel),
                .res  (result[i])
            );
        end
    end

    alu_flag_unit #(.W(W)) flags_i (
        .a_msb         (opa[MSB]),
        .b_msb         (b_eff[MSB]),
        .c_into_msb    (carry[MSB]),
        .c_out_msb     (carry[W]),
        .sel           (ctrl.sel),
        .unsigned_mode (unsigned_mode),
        .res           (result),
        .set_bit       (set_bit),
        .zero          (zero),
        .ovf           (ovf)
    );

endmodule

// File: rtl/sliced_alu_chk.sv
module sliced_alu_chk #(
    parameter int unsigned W = 32
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [3:0]   ctl,
    input logic         unsigned_mode,
    input logic [W-1:0] result,
    input logic         zero,
    input logic         ovf
);

    always_comb begin
        // R9
        if (unsigned_mode) begin
            unsigned_quiet_chk: assert (!ovf);
        end
        // R10
        if (ctl[2:0] != 3'b100) begin
            non_arith_ovf_chk: assert (!ovf);
        end
        // R8
        if (ctl == 4'b0100 && opa[W-1] != opb[W-1]) begin
            mixed_sign_add_chk: assert (!ovf);
        end
        // R8
        if (ctl == 4'b0100 && ovf) begin
            ovf_sign_flip_chk: assert (result[W-1] != opa[W-1]);
        end
        // R4
        if (ctl[2:0] == 3'b101 || ctl[2:0] == 3'b110) begin
            cmp_upper_clear_chk: assert (result[W-1:1] == '0);
        end
        // R6
        if (ctl[2:0] == 3'b111) begin
            rsvd_sel_chk: assert (result == '0 && zero && !ovf);
        end
    end

endmodule

bind sliced_alu sliced_alu_chk #(.W(W)) chk_i (
    .opa           (opa),
    .opb           (opb),
    .ctl           (ctl),
    .unsigned_mode (unsigned_mode),
    .result        (result),
    .zero          (zero),
    .ovf           (ovf)
);

// File: tb/sliced_alu_tb_top.sv
module sliced_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [3:0]  ctl = '0;
    logic        unsigned_mode = 1'b0;
    logic [31:0] result;
    logic        zero;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sliced_alu dut_i (
        .opa           (opa),
        .opb           (opb),
        .ctl           (ctl),
        .unsigned_mode (unsigned_mode),
        .result        (result),
        .zero          (zero),
        .ovf           (ovf)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic void ref_alu(input logic [31:0] a, input logic [31:0] b,
                                    input logic [3:0] c, input logic uns,
                                    output logic [31:0] r, output logic z,
                                    output logic v);
        logic [31:0] bb;
        bb = c[3] ? ~b : b;
        v  = 1'b0;
        case (c[2:0])
            3'd0: r = a & bb;
            3'd1: r = a | bb;
            3'd2: r = a ^ bb;
            3'd3: r = ~(a | bb);
            3'd4: begin
                if (c[3]) begin
                    r = a - b;
                    v = (a[31] != b[31]) && (r[31] != a[31]);
                end else begin
                    r = a + b;
                    v = (a[31] == b[31]) && (r[31] != a[31]);
                end
                if (uns) v = 1'b0;
            end
            3'd5: r = {31'd0, ($signed(a) < $signed(b))};
            3'd6: r = {31'd0, (a < b)};
            default: r = '0;
        endcase
        z = (r == 32'd0);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%h expected=%h (a=%h b=%h ctl=%b u=%b)",
                     req, what, act, exp, opa, opb, ctl, unsigned_mode);
        end
    endtask

    // drive on falling edge, sample one ns after the next rising edge
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] c, input logic uns, input string req);
        logic [31:0] er;
        logic ez;
        logic ev;
        @(negedge clk);
        opa = a; opb = b; ctl = c; unsigned_mode = uns;
        @(posedge clk);
        #1;
        ref_alu(a, b, c, uns, er, ez, ev);
        check(req, "result", result, er);
        check("R7", "zero", {31'd0, zero}, {31'd0, ez});
        check(req == "R9" ? "R9" : (c[2:0] == 3'd4 ? "R8" : "R10"), "ovf",
              {31'd0, ovf}, {31'd0, ev});
    endtask

    task automatic t_idle();
        @(posedge clk);
        #1;
        check("R1", "idle result", result, 32'd0);
        check("R7", "idle zero", {31'd0, zero}, 32'd1);
    endtask

    task automatic t_logic();
        for (int s = 0; s < 4; s++) begin
            for (int inv = 0; inv < 2; inv++) begin
                apply(32'hF0F0_3C3C, 32'hFF00_5A5A, {inv[0], s[2:0]}, 1'b0, "R1");
                apply(32'hFFFF_FFFF, 32'h0000_0000, {inv[0], s[2:0]}, 1'b0, "R1");
            end
        end
    endtask

    task automatic t_addsub();
        apply(32'd5, 32'd7, 4'b0100, 1'b0, "R2");
        apply(32'hFFFF_FFFF, 32'd1, 4'b0100, 1'b0, "R2");
        apply(32'd5, 32'd7, 4'b1100, 1'b0, "R3");
        apply(32'd9, 32'd9, 4'b1100, 1'b0, "R3");
    endtask

    task automatic t_overflow();
        apply(32'h7FFF_FFFF, 32'd1, 4'b0100, 1'b0, "R8");
        apply(32'h8000_0000, 32'h8000_0000, 4'b0100, 1'b0, "R8");
        apply(32'h8000_0000, 32'd1, 4'b1100, 1'b0, "R8");
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b1100, 1'b0, "R8");
        apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0100, 1'b0, "R8");
        apply(32'h8000_0000, 32'h7FFF_FFFF, 4'b0100, 1'b0, "R8");
    endtask

    task automatic t_compare();
        for (int inv = 0; inv < 2; inv++) begin
            apply(32'h8000_0000, 32'd1, {inv[0], 3'b101}, 1'b0, "R4");
            apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, {inv[0], 3'b101}, 1'b0, "R4");
            apply(32'd3, 32'd3, {inv[0], 3'b101}, 1'b0, "R4");
            apply(32'hFFFF_FFFE, 32'hFFFF_FFFF, {inv[0], 3'b101}, 1'b0, "R4");
            apply(32'h8000_0000, 32'd1, {inv[0], 3'b110}, 1'b0, "R5");
            apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, {inv[0], 3'b110}, 1'b0, "R5");
            apply(32'd0, 32'd0, {inv[0], 3'b110}, 1'b0, "R5");
            apply(32'd0, 32'hFFFF_FFFF, {inv[0], 3'b110}, 1'b0, "R5");
        end
    endtask

    task automatic t_reserved();
        apply(32'hDEAD_BEEF, 32'h1234_5678, 4'b0111, 1'b0, "R6");
        apply(32'h7FFF_FFFF, 32'd1, 4'b1111, 1'b0, "R6");
    endtask

    task automatic t_unsigned();
        apply(32'h7FFF_FFFF, 32'd1, 4'b0100, 1'b1, "R9");
        apply(32'h8000_0000, 32'd1, 4'b1100, 1'b1, "R9");
        apply(32'h8000_0000, 32'h8000_0000, 4'b0100, 1'b1, "R9");
    endtask

    task automatic t_random();
        for (int n = 0; n < 400; n++) begin
            logic [3:0] c;
            c = 4'($urandom_range(0, 15));
            apply($urandom, $urandom, c, 1'($urandom_range(0, 1)),
                  c[2:0] == 3'd4 ? (c[3] ? "R3" : "R2") :
                  c[2:0] == 3'd5 ? "R4" : c[2:0] == 3'd6 ? "R5" :
                  c[2:0] == 3'd7 ? "R6" : "R1");
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_logic();
        t_addsub();
        t_overflow();
        t_compare();
        t_reserved();
        t_unsigned();
        t_random();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule